// File: doc/BRIEF.md
# Early Capture Extension for Boundary-Scan Capture Paths

This block lets a boundary-scan capture path sample pin data a fraction of a TCK period after the update edge, instead of waiting the usual 2.5 or more TCK cycles for the Capture-DR rising edge. The test controller drops TMS while the TAP sits in Update-DR. The TAP ignores this edge, because TMS only matters on rising TCK. The block treats the same edge as a sampling strobe. The tester places that TMS edge relative to the TCK falling edge that drives the outputs, so it sets the measured delay directly.

A single flag records that such a strobe occurred. The flag has two states. OPEN means no early sample is pending. FROZEN means a strobe was seen. The transition OPEN→FROZEN happens on a TMS falling edge while Update-DR is active. A TMS falling edge in any other TAP state leaves the flag in OPEN. The transition FROZEN→OPEN is asynchronous and is caused by Shift-DR or by TAP reset.

The flag is gated by an enable bit from the instruction decode to form an active-low early-capture signal. While that signal is high, the holding latch in front of every capture input passes the live pin through. When the signal is low, the latches keep the value the pins had at the TMS edge. That value stays in place through the normal Capture-DR edge and is released once Shift-DR begins. With the enable bit off, the block has no effect.

Top module: `ecap_top`

## Requirements
- R1: While `tap_rst` is high, the flag is OPEN and `ec_n` is 1. A reset pulse ends any hold, and `held_o` then follows `pin_i` again.
- R2: A falling edge on `tms` while `upd_dr` is 1 moves the flag to FROZEN. A falling edge on `tms` while `upd_dr` is 0 leaves `ec_n` at 1.
- R3: While `shift_dr` is 1, the flag is OPEN and `ec_n` is 1. The clear takes effect without waiting for any clock edge.
- R4: `ec_n` is 0 only when the flag is FROZEN and `ec_en` is 1. With `ec_en` at 0, the value seen at Capture-DR is the live pin, exactly as in a part without the extension.
- R5: While `ec_n` is 1, every bit of `held_o` equals the matching bit of `pin_i`.
- R6: While `ec_n` is 0, `held_o` keeps the value `pin_i` had at the TMS falling edge. Later pin changes are ignored through the Capture-DR rising edge, until the flag is cleared.
- R7: Both exits from Update-DR work. The first is an exit to Run-Test-Idle, where TMS stays low after its natural falling edge. The second is an exit straight to Select-DR, where a short low pulse on TMS returns high before the next rising TCK.
- R8: If TCK pulses are withheld so the TAP stays in Update-DR for several periods, a TMS falling edge late in that stretch samples the pin at that late instant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; reference for the checking logic |
| tms | input | 1 | Test mode select; its falling edge is the early strobe |
| tap_rst | input | 1 | TAP reset, active high, clears the flag asynchronously |
| upd_dr | input | 1 | TAP is in Update-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| ec_en | input | 1 | Early-capture enable from the instruction decode |
| pin_i | input | N_CAP | Live pin data, one bit per capture input |
| ec_n | output | 1 | Early-capture signal, active low |
| held_o | output | N_CAP | Latched data presented to each capture input |

## Verification
The assertions check several rules on every TCK edge. The flag may rise only while Update-DR is active. Shift-DR and reset always leave `ec_n` high. A cleared enable keeps `ec_n` high. The latches are transparent whenever `ec_n` is high, and their contents cannot move while `ec_n` stays low. The timing relation itself can only be shown by the bench scenarios. In those scenarios the TMS edge is placed before or after the pin transition, and the check is that Capture-DR sees the pin level at the strobe rather than the later level. The scenarios cover both Update-DR exits, stretched Update-DR dwells, reset during a hold, and the disabled case.

// File: rtl/ecap_pkg.sv
`timescale 1ns/1ps
package ecap_pkg;
    typedef enum logic {
        EC_OPEN   = 1'b0,
        EC_FROZEN = 1'b1
    } ec_state_e;
endpackage

// File: rtl/ecap_arm.sv
`timescale 1ns/1ps
// Strobe flag: set by a TMS falling edge during Update-DR, cleared asynchronously.
module ecap_arm
    import ecap_pkg::*;
(
    input  logic tck,
    input  logic tms,
    input  logic upd_dr,
    input  logic clr,
    input  logic shift_dr,
    output logic armed_o
);
    ec_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EC_OPEN:   if (upd_dr) st_d = EC_FROZEN;
            EC_FROZEN: st_d = EC_FROZEN;
        endcase
    end

    always_ff @(negedge tms or posedge clr) begin
        if (clr) st_q <= EC_OPEN;
        else     st_q <= st_d;
    end

    always_comb begin
        armed_o = (st_q == EC_FROZEN);
    end

    // R2: the flag may only become set while Update-DR is active
    assert_set_in_update_R2: assert property (@(posedge tck) disable iff (clr)
        $rose(armed_o) |-> upd_dr);

    // R3: Shift-DR leaves the flag cleared
    assert_shift_clears_R3: assert property (@(posedge tck)
        shift_dr |-> !armed_o);
endmodule

// File: rtl/ecap_gate.sv
`timescale 1ns/1ps
// Combines the flag with the enable bit into the active-low strobe.
module ecap_gate (
    input  logic tck,
    input  logic tap_rst,
    input  logic armed_i,
    input  logic ec_en,
    output logic ec_n
);
    always_comb begin
        ec_n = ~(armed_i & ec_en);
    end

    // R4: with the enable off the part behaves as a standard one
    assert_disabled_idle_R4: assert property (@(posedge tck) disable iff (tap_rst)
        !ec_en |-> ec_n);

    // R1: reset always releases the strobe
    assert_reset_release_R1: assert property (@(posedge tck)
        tap_rst |-> ec_n);
endmodule

// File: rtl/ecap_hold.sv
`timescale 1ns/1ps
// One holding latch per capture input, transparent while ec_n is high.
module ecap_hold #(
    parameter int N_CAP = 4
) (
    input  logic             tck,
    input  logic             tap_rst,
    input  logic             ec_n,
    input  logic [N_CAP-1:0] pin_i,
    output logic [N_CAP-1:0] held_o
);
    for (genvar gi = 0; gi < N_CAP; gi++) begin : g_cell
        logic q;
        always_latch begin
            if (ec_n) q = pin_i[gi];
        end
        assign held_o[gi] = q;
    end

    // R5: transparent whenever the strobe is released
    assert_transparent_R5: assert property (@(negedge tck) disable iff (tap_rst)
        ec_n |-> (held_o == pin_i));

    // R6: contents frozen while the strobe stays low
    assert_hold_stable_R6: assert property (@(posedge tck) disable iff (tap_rst)
        (!ec_n && $past(!ec_n)) |-> $stable(held_o));
endmodule

// File: rtl/ecap_top.sv
`timescale 1ns/1ps
module ecap_top #(
    parameter int N_CAP = 4
) (
    input  logic             tck,
    input  logic             tms,
    input  logic             tap_rst,
    input  logic             upd_dr,
    input  logic             shift_dr,
    input  logic             ec_en,
    input  logic [N_CAP-1:0] pin_i,
    output logic             ec_n,
    output logic [N_CAP-1:0] held_o
);
    localparam int CapMsb = N_CAP - 1;

    logic clr;
    logic armed;

    assign clr = tap_rst | shift_dr;

    ecap_arm u_arm (
        .tck      (tck),
        .tms      (tms),
        .upd_dr   (upd_dr),
        .clr      (clr),
        .shift_dr (shift_dr),
        .armed_o  (armed)
    );

    ecap_gate u_gate (
        .tck     (tck),
        .tap_rst (tap_rst),
        .armed_i (armed),
        .ec_en   (ec_en),
        .ec_n    (ec_n)
    );

    ecap_hold #(.N_CAP(N_CAP)) u_hold (
        .tck     (tck),
        .tap_rst (tap_rst),
        .ec_n    (ec_n),
        .pin_i   (pin_i[CapMsb:0]),
        .held_o  (held_o)
    );
endmodule

// File: tb/ecap_top_tb.sv
`timescale 1ns/1ps
module ecap_top_tb;
    localparam int N = 4;

    logic         tck = 1'b0;
    logic         tms = 1'b1;
    logic         tap_rst = 1'b0;
    logic         upd_dr = 1'b0;
    logic         shift_dr = 1'b0;
    logic         ec_en = 1'b0;
    logic [N-1:0] pin = '0;
    logic         ec_n;
    logic [N-1:0] held;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    ecap_top #(.N_CAP(N)) u_dut (
        .tck(tck), .tms(tms), .tap_rst(tap_rst), .upd_dr(upd_dr),
        .shift_dr(shift_dr), .ec_en(ec_en), .pin_i(pin),
        .ec_n(ec_n), .held_o(held)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one 100 MHz TCK period, starting and ending low
    task automatic tick();
        #5 tck = 1'b1;
        #5 tck = 1'b0;
    endtask

    function automatic logic [N-1:0] f_expect(input bit en, input int toff, input int pdel,
                                              input logic [N-1:0] pb, input logic [N-1:0] pa,
                                              input logic [N-1:0] pl);
        if (!en) return pl;
        return (toff < pdel) ? pb : pa;
    endfunction

    // One Update-DR -> Capture-DR -> Shift-DR pass.
    // sel=0: exit to Run-Test-Idle; sel=1: straight to Select-DR with a TMS low pulse.
    task automatic scan(input bit en, input bit sel, input int dwell, input int toff,
                        input int pdel, input logic [N-1:0] pb, input logic [N-1:0] pa,
                        input logic [N-1:0] pl, input string tag);
        logic [N-1:0] exp;
        exp = f_expect(en, toff, pdel, pb, pa, pl);
        ec_en = en;
        tms = 1'b1;
        pin = pb;
        #5 tck = 1'b1;          // edge entering Update-DR
        #1 upd_dr = 1'b1;
        #4 tck = 1'b0;          // output update edge
        fork
            begin #(toff) tms = 1'b0; if (sel) begin #1 tms = 1'b1; end end
            begin #(pdel) pin = pa; end
            begin #(5 + 10*dwell); end
        join
        tck = 1'b1;             // leave Update-DR
        #1 upd_dr = 1'b0;
        #1 pin = pl;
        #3 tck = 1'b0;
        if (!sel) begin
            tms = 1'b1; tick();  // Run-Test-Idle -> Select-DR
        end
        tms = 1'b0; tick();      // Select-DR -> Capture-DR
        #2;
        chk({tag, " R4 strobe level at Capture-DR"}, ec_n, !en);
        chk({tag, " R6 value seen by Capture-DR"}, held, exp);
        #3 tck = 1'b1;           // capture edge
        #1 shift_dr = 1'b1;
        #1;
        chk({tag, " R3 strobe released in Shift-DR"}, ec_n, 1);
        chk({tag, " R5 latch transparent after clear"}, held, pl);
        #3 tck = 1'b0;
        tick();
        shift_dr = 1'b0;
        tms = 1'b1;
        tick();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #1 tap_rst = 1'b1;
        pin = 4'h5;
        tick(); tick();
        #2;
        chk("R1 ec_n during reset", ec_n, 1);
        chk("R1 latch follows pin during reset", held, 4'h5);
        tap_rst = 1'b0;
        tick();

        // R2: TMS falling outside Update-DR has no effect
        ec_en = 1'b1;
        #2 tms = 1'b0;
        #1 pin = 4'hA;
        #1;
        chk("R2 TMS fall outside Update-DR", ec_n, 1);
        chk("R5 transparent after ignored edge", held, 4'hA);
        tms = 1'b1;
        #6 tick();

        // R1/R6: hold then reset pulse
        upd_dr = 1'b1;
        pin = 4'h3;
        #2 tms = 1'b0;
        #1;
        chk("R2 flag set in Update-DR", ec_n, 0);
        pin = 4'hC;
        #1;
        chk("R6 hold ignores later pin change", held, 4'h3);
        ec_en = 1'b0;
        #1;
        chk("R4 enable off releases strobe", ec_n, 1);
        chk("R4 enable off passes live pin", held, 4'hC);
        ec_en = 1'b1;
        pin = 4'h9;
        #1;
        chk("R4 enable back on re-arms strobe", ec_n, 0);
        tap_rst = 1'b1;
        #1;
        chk("R1 reset ends hold", ec_n, 1);
        chk("R1 latch follows pin after reset", held, 4'h9);
        tap_rst = 1'b0;
        upd_dr = 1'b0;
        tms = 1'b1;
        #3 tick();

        // directed scans
        scan(1, 0, 0, 1, 3, 4'h1, 4'hE, 4'h7, "R7 natural early edge");
        scan(1, 1, 0, 3, 1, 4'h2, 4'hD, 4'h8, "R7 pulse late edge");
        scan(1, 1, 0, 1, 2, 4'h6, 4'h9, 4'h0, "R7 pulse early edge");
        scan(1, 0, 2, 22, 15, 4'h4, 4'hB, 4'h1, "R8 long dwell late edge");
        scan(1, 1, 3, 2, 31, 4'hF, 4'h0, 4'h5, "R8 long dwell early edge");
        scan(0, 0, 1, 4, 8, 4'h3, 4'hC, 4'hA, "R4 disabled");

        // constrained random scans
        for (int k = 0; k < 40; k++) begin
            int dw, w, to, pd;
            bit en, sl;
            dw = int'($urandom % 3);
            w  = 10*dw + 3;
            to = 1 + int'($urandom % w);
            pd = 1 + int'($urandom % w);
            if (pd == to) pd = pd + 1;
            en = ($urandom % 4) != 0;
            sl = $urandom % 2;
            scan(en, sl, dw, to, pd, 4'($urandom), 4'($urandom), 4'($urandom),
                 sl ? "R7 random pulse" : "R6 random natural");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule